// File: doc/BRIEF.md
# Double-Buffered Frame Store Controller

This block sits between a display timing generator, two external pixel SRAMs and two writers: a graphics engine and a host CPU. One SRAM holds the frame on screen. The controller addresses it from its own scan X/Y counters and returns each fetched 12-bit pixel (4 bits each of red, green and blue) on a registered output. The other SRAM is free for drawing. The graphics engine can write to it, and the CPU can write to it or read from it. Only one of the two writers reaches it in any cycle, and the graphics engine takes priority.

The host asks for the buffers to trade places by pulsing a flip request. The controller holds that request until the next rising edge of vertical sync. At that edge it toggles one select bit, and that bit swaps the scan path and the writer path between the two SRAMs together. All writer traffic goes through a register stage before it reaches an SRAM, so every SRAM access lines up with the clock. The active area is 640x480, so the scan counters are 10 bits for X and 9 bits for Y. They advance and wrap under control of the timing inputs.

Top module: `dbf_frame_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `disp_sel` is 0, neither SRAM write enable is high, `cpu_rvalid` is 0 and `pix_out` is 0.
- R2: When `pix_en` is high, the scan X counter goes to 0 if `h_wrap` is high and otherwise adds 1. The Y counter changes only when `pix_en` and `h_wrap` are both high: it goes to 0 if `v_wrap` is high and otherwise adds 1. Both counters hold when `pix_en` is low. The scan address is Y in the upper bits and X in the lower bits, {Y, X}.
- R3: The displayed SRAM is A when `disp_sel` is 0 and B when it is 1. Its address is always the scan address, and its write enable and write data stay 0.
- R4: A `flip_req` pulse is remembered. At the first cycle in which `vsync` goes from 0 to 1, `disp_sel` toggles on the following clock edge and the stored request is cleared. A request made in that same rising cycle is also honoured.
- R5: A flip request that arrives while `vsync` is not rising has no effect until the next rising edge. Several requests made before one rising edge produce a single toggle. A rising edge with no request pending leaves `disp_sel` unchanged.
- R6: A graphics-engine write (`gpu_we` high) is presented on the idle SRAM one cycle later: its address, its data and a write enable of 1.
- R7: A CPU request (`cpu_req` high) made while `gpu_we` is low is accepted. One cycle later it appears on the idle SRAM with the CPU address and data, and with write enable equal to `cpu_we`.
- R8: `cpu_ready` is the inverse of `gpu_we`. When both writers request in the same cycle, only the graphics-engine access reaches the SRAM.
- R9: An accepted CPU read (`cpu_we` low) raises `cpu_rvalid` for one cycle, two cycles after the request. At that point `cpu_rdata` holds the idle SRAM's read data from the cycle in which the read was presented.
- R10: `pix_out` holds the displayed SRAM's read data from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Scan counters advance in this cycle |
| h_wrap | input | 1 | End of line from the timing generator |
| v_wrap | input | 1 | End of frame from the timing generator |
| vsync | input | 1 | Vertical sync level |
| flip_req | input | 1 | Host request to swap the buffers |
| disp_sel | output | 1 | Displayed buffer (0 = A, 1 = B) |
| gpu_we | input | 1 | Graphics-engine write strobe |
| gpu_addr | input | 19 | Graphics-engine pixel address |
| gpu_wdata | input | 12 | Graphics-engine pixel data |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 19 | CPU pixel address |
| cpu_wdata | input | 12 | CPU write data |
| cpu_ready | output | 1 | CPU request can be taken in this cycle |
| cpu_rvalid | output | 1 | CPU read data valid |
| cpu_rdata | output | 12 | CPU read data |
| sa_addr | output | 19 | SRAM A address |
| sa_wdata | output | 12 | SRAM A write data |
| sa_we | output | 1 | SRAM A write enable |
| sa_rdata | input | 12 | SRAM A read data |
| sb_addr | output | 19 | SRAM B address |
| sb_wdata | output | 12 | SRAM B write data |
| sb_we | output | 1 | SRAM B write enable |
| sb_rdata | input | 12 | SRAM B read data |
| pix_out | output | 12 | Registered display pixel |

## Verification
Two pairs of events can fall in the same cycle. A buffer swap can coincide with a staged write, and a graphics-engine write can coincide with a CPU request. The bench provokes the first by raising `vsync` while writes are in flight, and by placing a flip request in the very cycle of the vsync rise. In each case a behavioural model decides which SRAM must receive the write after the swap. The bench provokes the second by driving `gpu_we` and `cpu_req` together over directed and random stretches, and compares `cpu_ready`, both SRAM ports and the read-return pipeline against the model on every clock.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_GPU, SRC_CPU} wr_src_e;

  // The graphics engine always wins; the CPU is served only when it is idle.
  function automatic wr_src_e pick_writer(input logic gpu_we, input logic cpu_req);
    if (gpu_we)       return SRC_GPU;
    else if (cpu_req) return SRC_CPU;
    else              return SRC_NONE;
  endfunction
endpackage

// File: rtl/dbf_scan_ctr.sv
module dbf_scan_ctr #(
  parameter int X_W = 10,
  parameter int Y_W = 9,
  localparam int A_W = X_W + Y_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_en,
  input  logic           h_wrap,
  input  logic           v_wrap,
  output logic [A_W-1:0] scan_addr
);
  logic [X_W-1:0] x_q;
  logic [Y_W-1:0] y_q;

  function automatic logic [X_W-1:0] x_step(input logic [X_W-1:0] x, input logic en, input logic wrap);
    if (!en)  return x;
    if (wrap) return '0;
    return x + 1'b1;
  endfunction

  function automatic logic [Y_W-1:0] y_step(input logic [Y_W-1:0] y, input logic line_end, input logic wrap);
    if (!line_end) return y;
    if (wrap)      return '0;
    return y + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      x_q <= x_step(x_q, pix_en, h_wrap);
      y_q <= y_step(y_q, pix_en && h_wrap, v_wrap);
    end
  end

  assign scan_addr = {y_q, x_q};
endmodule

// File: rtl/dbf_flip_ctl.sv
module dbf_flip_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic flip_req,
  output logic disp_sel,
  output logic flip_pend,
  output logic vs_rise,
  output logic swap
);
  logic vsync_q;

  assign vs_rise = vsync && !vsync_q;
  assign swap    = vs_rise && (flip_pend || flip_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vsync_q   <= 1'b0;
      flip_pend <= 1'b0;
      disp_sel  <= 1'b0;
    end else begin
      vsync_q   <= vsync;
      flip_pend <= swap ? 1'b0 : (flip_pend || flip_req);
      if (swap) disp_sel <= !disp_sel;
    end
  end
endmodule

// File: rtl/dbf_wr_arb.sv
module dbf_wr_arb
  import dbf_pkg::*;
#(
  parameter int A_W = 19,
  parameter int D_W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           gpu_we,
  input  logic [A_W-1:0] gpu_addr,
  input  logic [D_W-1:0] gpu_wdata,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [A_W-1:0] cpu_addr,
  input  logic [D_W-1:0] cpu_wdata,
  output logic           gpu_grant,
  output logic           cpu_grant,
  output logic           cpu_ready,
  output logic           stg_we,
  output logic           stg_rd,
  output logic [A_W-1:0] stg_addr,
  output logic [D_W-1:0] stg_data
);
  wr_src_e src;

  assign src       = pick_writer(gpu_we, cpu_req);
  assign gpu_grant = (src == SRC_GPU);
  assign cpu_grant = (src == SRC_CPU);
  assign cpu_ready = !gpu_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_we   <= 1'b0;
      stg_rd   <= 1'b0;
      stg_addr <= '0;
      stg_data <= '0;
    end else begin
      stg_we   <= gpu_grant || (cpu_grant && cpu_we);
      stg_rd   <= cpu_grant && !cpu_we;
      stg_addr <= gpu_we ? gpu_addr  : cpu_addr;
      stg_data <= gpu_we ? gpu_wdata : cpu_wdata;
    end
  end
endmodule

// File: rtl/dbf_frame_ctrl.sv
module dbf_frame_ctrl #(
  parameter int X_W = 10,
  parameter int Y_W = 9,
  parameter int CH_W = 4,
  localparam int A_W = X_W + Y_W,
  localparam int D_W = 3 * CH_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pix_en,
  input  logic           h_wrap,
  input  logic           v_wrap,
  input  logic           vsync,
  input  logic           flip_req,
  output logic           disp_sel,
  input  logic           gpu_we,
  input  logic [A_W-1:0] gpu_addr,
  input  logic [D_W-1:0] gpu_wdata,
  input  logic           cpu_req,
  input  logic           cpu_we,
  input  logic [A_W-1:0] cpu_addr,
  input  logic [D_W-1:0] cpu_wdata,
  output logic           cpu_ready,
  output logic           cpu_rvalid,
  output logic [D_W-1:0] cpu_rdata,
  output logic [A_W-1:0] sa_addr,
  output logic [D_W-1:0] sa_wdata,
  output logic           sa_we,
  input  logic [D_W-1:0] sa_rdata,
  output logic [A_W-1:0] sb_addr,
  output logic [D_W-1:0] sb_wdata,
  output logic           sb_we,
  input  logic [D_W-1:0] sb_rdata,
  output logic [D_W-1:0] pix_out
);
  logic           flip_pend, vs_rise, swap;
  logic           gpu_grant, cpu_grant;
  logic           stg_we, stg_rd;
  logic [A_W-1:0] stg_addr;
  logic [D_W-1:0] stg_data;
  logic [A_W-1:0] scan_addr [2];
  logic [A_W-1:0] port_addr [2];
  logic [D_W-1:0] port_wdata [2];
  logic           port_we [2];
  logic [D_W-1:0] port_rdata [2];
  logic [D_W-1:0] disp_rdata, idle_rdata;

  dbf_flip_ctl u_flip (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .flip_req(flip_req),
    .disp_sel(disp_sel), .flip_pend(flip_pend), .vs_rise(vs_rise), .swap(swap)
  );

  dbf_wr_arb #(.A_W(A_W), .D_W(D_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .gpu_we(gpu_we), .gpu_addr(gpu_addr), .gpu_wdata(gpu_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .gpu_grant(gpu_grant), .cpu_grant(cpu_grant), .cpu_ready(cpu_ready),
    .stg_we(stg_we), .stg_rd(stg_rd), .stg_addr(stg_addr), .stg_data(stg_data)
  );

  assign port_rdata[0] = sa_rdata;
  assign port_rdata[1] = sb_rdata;

  // One scan counter and one address/data switch per buffer.
  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic on_screen;
    assign on_screen = (disp_sel == g[0]);

    dbf_scan_ctr #(.X_W(X_W), .Y_W(Y_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
      .h_wrap(h_wrap), .v_wrap(v_wrap), .scan_addr(scan_addr[g])
    );

    assign port_addr[g]  = on_screen ? scan_addr[g] : stg_addr;
    assign port_wdata[g] = on_screen ? '0 : stg_data;
    assign port_we[g]    = !on_screen && stg_we;
  end

  assign sa_addr  = port_addr[0];
  assign sa_wdata = port_wdata[0];
  assign sa_we    = port_we[0];
  assign sb_addr  = port_addr[1];
  assign sb_wdata = port_wdata[1];
  assign sb_we    = port_we[1];

  assign disp_rdata = port_rdata[disp_sel];
  assign idle_rdata = port_rdata[!disp_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out    <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      pix_out    <= disp_rdata;
      cpu_rvalid <= stg_rd;
      if (stg_rd) cpu_rdata <= idle_rdata;
    end
  end
endmodule

// File: rtl/dbf_frame_ctrl_chk.sv
module dbf_frame_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic disp_sel,
  input logic vs_rise,
  input logic swap,
  input logic flip_pend,
  input logic gpu_grant,
  input logic cpu_grant,
  input logic gpu_we,
  input logic cpu_req,
  input logic cpu_ready,
  input logic sa_we,
  input logic sb_we,
  input logic stg_rd,
  input logic cpu_rvalid
);
  AST_SEL_ONLY_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_sel) |-> $past(vs_rise)); // R4
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> !flip_pend); // R4
  AST_DISP_A_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sa_we |-> disp_sel); // R3
  AST_DISP_B_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sb_we |-> !disp_sel); // R3
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpu_grant, cpu_grant})); // R8
  AST_CPU_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (gpu_we && cpu_req) |-> (!cpu_ready && !cpu_grant)); // R8
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    stg_rd |=> cpu_rvalid); // R9
  AST_RVALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(stg_rd)); // R9
endmodule

bind dbf_frame_ctrl dbf_frame_ctrl_chk u_chk (.*);

// File: tb/dbf_frame_ctrl_tb.sv
module dbf_frame_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 0, h_wrap = 0, v_wrap = 0, vsync = 0, flip_req = 0;
  logic gpu_we = 0, cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] gpu_addr = '0, cpu_addr = '0;
  logic [DW-1:0] gpu_wdata = '0, cpu_wdata = '0;
  logic disp_sel, cpu_ready, cpu_rvalid, sa_we, sb_we;
  logic [DW-1:0] cpu_rdata, sa_wdata, sb_wdata, sa_rdata, sb_rdata, pix_out;
  logic [AW-1:0] sa_addr, sb_addr;

  logic [DW-1:0] mem_a [256];
  logic [DW-1:0] mem_b [256];

  int n_chk = 0, n_bad = 0;

  // Reference model state
  int m_x, m_y, m_sel, m_pend, m_vsq, m_swe, m_srd, m_rv;
  int m_saddr, m_sdata, m_rdat, m_pix;

  always #(CLK_PERIOD/2) clk = !clk;

  dbf_frame_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .h_wrap(h_wrap), .v_wrap(v_wrap),
    .vsync(vsync), .flip_req(flip_req), .disp_sel(disp_sel),
    .gpu_we(gpu_we), .gpu_addr(gpu_addr), .gpu_wdata(gpu_wdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .sa_addr(sa_addr), .sa_wdata(sa_wdata), .sa_we(sa_we), .sa_rdata(sa_rdata),
    .sb_addr(sb_addr), .sb_wdata(sb_wdata), .sb_we(sb_we), .sb_rdata(sb_rdata),
    .pix_out(pix_out)
  );

  // Asynchronous-read SRAM models, low 8 address bits decoded
  assign sa_rdata = mem_a[sa_addr[7:0]];
  assign sb_rdata = mem_b[sb_addr[7:0]];
  always @(posedge clk) begin
    if (sa_we) mem_a[sa_addr[7:0]] <= sa_wdata;
    if (sb_we) mem_b[sb_addr[7:0]] <= sb_wdata;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic int rd_mem(input int sel, input int addr);
    return sel ? int'(mem_b[addr[7:0]]) : int'(mem_a[addr[7:0]]);
  endfunction

  task automatic model_reset();
    m_x = 0; m_y = 0; m_sel = 0; m_pend = 0; m_vsq = 0;
    m_swe = 0; m_srd = 0; m_rv = 0; m_saddr = 0; m_sdata = 0; m_rdat = 0; m_pix = 0;
  endtask

  // Compare all outputs, then advance the model by one clock.
  task automatic step();
    int scan, n_x, n_y, n_sel, n_pend, n_swe, n_srd, n_addr, n_data, n_rdat, n_pix;
    int rise, swp;
    #1;
    scan = (m_y << 10) | m_x;
    chk("R4,R5 disp_sel", int'(disp_sel), m_sel);
    chk("R8 cpu_ready", int'(cpu_ready), int'(!gpu_we));
    if (m_sel == 0) begin
      chk("R2,R3 disp addr A", int'(sa_addr), scan);
      chk("R3 disp we A", int'(sa_we), 0);
      chk("R3 disp wdata A", int'(sa_wdata), 0);
      chk("R6,R7 idle addr B", int'(sb_addr), m_saddr);
      chk("R6,R7 idle we B", int'(sb_we), m_swe);
      chk("R6,R7 idle wdata B", int'(sb_wdata), m_sdata);
    end else begin
      chk("R2,R3 disp addr B", int'(sb_addr), scan);
      chk("R3 disp we B", int'(sb_we), 0);
      chk("R3 disp wdata B", int'(sb_wdata), 0);
      chk("R6,R7 idle addr A", int'(sa_addr), m_saddr);
      chk("R6,R7 idle we A", int'(sa_we), m_swe);
      chk("R6,R7 idle wdata A", int'(sa_wdata), m_sdata);
    end
    chk("R9 cpu_rvalid", int'(cpu_rvalid), m_rv);
    if (m_rv != 0) chk("R9 cpu_rdata", int'(cpu_rdata), m_rdat);
    chk("R10 pix_out", int'(pix_out), m_pix);

    rise   = (vsync && m_vsq == 0) ? 1 : 0;
    swp    = (rise != 0 && (m_pend != 0 || flip_req)) ? 1 : 0;
    n_sel  = m_sel ^ swp;
    n_pend = swp ? 0 : ((m_pend != 0 || flip_req) ? 1 : 0);
    n_x = m_x; n_y = m_y;
    if (pix_en) begin
      n_x = h_wrap ? 0 : (m_x + 1) % 1024;
      if (h_wrap) n_y = v_wrap ? 0 : (m_y + 1) % 512;
    end
    n_swe  = (gpu_we || (cpu_req && cpu_we)) ? 1 : 0;
    n_srd  = (!gpu_we && cpu_req && !cpu_we) ? 1 : 0;
    n_addr = gpu_we ? int'(gpu_addr) : int'(cpu_addr);
    n_data = gpu_we ? int'(gpu_wdata) : int'(cpu_wdata);
    n_rdat = m_srd ? rd_mem(1 - m_sel, m_saddr) : m_rdat;
    n_pix  = rd_mem(m_sel, scan);
    @(posedge clk);
    m_vsq = vsync; m_sel = n_sel; m_pend = n_pend; m_x = n_x; m_y = n_y;
    m_rv = m_srd; m_rdat = n_rdat; m_swe = n_swe; m_srd = n_srd;
    m_saddr = n_addr; m_sdata = n_data; m_pix = n_pix;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    pix_en = 0; h_wrap = 0; v_wrap = 0; flip_req = 0;
    gpu_we = 0; cpu_req = 0; cpu_we = 0;
  endtask

  task automatic gpu_write(input int a, input int d);
    gpu_we = 1; gpu_addr = AW'(a); gpu_wdata = DW'(d);
  endtask

  task automatic cpu_access(input int we, input int a, input int d);
    cpu_req = 1; cpu_we = we[0]; cpu_addr = AW'(a); cpu_wdata = DW'(d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state, also while reset is held
    chk("R1 disp_sel", int'(disp_sel), 0);
    chk("R1 sa_we", int'(sa_we), 0);
    chk("R1 sb_we", int'(sb_we), 0);
    chk("R1 cpu_rvalid", int'(cpu_rvalid), 0);
    chk("R1 pix_out", int'(pix_out), 0);
    rst_n = 1;
    step();

    // R6: graphics writes into idle B while the scan runs with line wraps (R2)
    for (int i = 0; i < 24; i++) begin
      idle_inputs();
      pix_en = 1; h_wrap = (i % 8 == 7); v_wrap = (i == 23);
      gpu_write(i, 12'h100 + i);
      step();
    end
    // R7: CPU writes with the graphics engine idle
    for (int i = 0; i < 8; i++) begin
      idle_inputs(); cpu_access(1, 32 + i, 12'h200 + i); step();
    end
    // R8: both request; graphics engine wins
    for (int i = 0; i < 6; i++) begin
      idle_inputs(); gpu_write(48 + i, 12'h300 + i); cpu_access(1, 48 + i, 12'hEEE); step();
    end
    // R9: CPU reads back, back to back
    for (int i = 0; i < 8; i++) begin
      idle_inputs(); cpu_access(0, i * 7, 0); step();
    end
    idle_inputs(); step(); step();

    // R5: request outside vsync waits; multiple requests give one toggle
    idle_inputs(); flip_req = 1; step();
    idle_inputs(); step(); flip_req = 1; step();
    idle_inputs(); repeat (3) step();
    vsync = 1; gpu_write(5, 12'hABC); step();   // R4 rise with a write in flight
    idle_inputs(); gpu_write(6, 12'hDEF); step();
    idle_inputs(); repeat (3) step();
    vsync = 0; step();
    vsync = 1; step();                           // R5 rise with nothing pending
    vsync = 0; step();
    // R4: request in the very cycle of the rise
    flip_req = 1; vsync = 1; step();
    idle_inputs(); step(); vsync = 0; step();

    // R10: scan the buffer back on screen
    for (int i = 0; i < 64; i++) begin
      idle_inputs(); pix_en = 1; h_wrap = (i % 16 == 15); v_wrap = (i == 63); step();
    end

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      pix_en = ($urandom % 4 != 0);
      h_wrap = ($urandom % 12 == 0);
      v_wrap = ($urandom % 5 == 0);
      vsync  = ($urandom % 6 == 0) ? !vsync : vsync;
      flip_req = ($urandom % 30 == 0);
      if ($urandom % 3 == 0) gpu_write($urandom % 1024, $urandom % 4096);
      if ($urandom % 2 == 0) cpu_access($urandom % 2, $urandom % 1024, $urandom % 4096);
      step();
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule